// File: doc/BRIEF.md
# Differential 8-Phase Tribit Detector

This block recovers three data bits per signalling interval from a differentially coherent 8-phase PSK receiver. At each interval strobe it takes four samples of the current symbol and two sets of four samples from the previous symbol. Those two sets have already been delayed by one interval and passed through analog phase shifters of −22.5° and +67.5°. Every sample arrives as an 8-bit complementary offset binary code.

Each code is converted to a signed value. The block forms two correlations, each as a sum of four products, and keeps only the upper half of every product. The in-phase sum F pairs the current samples with the −22.5° set. The quadrature sum Q pairs them with the +67.5° set. Both sums are clamped to a signed accumulator width.

The tribit is decided from the sign of Q, the sign of F, and whether |F| exceeds |Q|. It is then shifted out one bit per bit-clock tick, each bit with a one-cycle valid pulse. A new interval strobe drops any bits not yet sent.

Top module: `tribit_detector`

## Requirements
- R1: Each 8-bit sample code c is read as complementary offset binary, so its signed value is 127 − c (code 0x7F is zero, 0x00 is +127, 0xFF is −128).
- R2: F is the sum, over the four sample positions, of the truncated product of the current sample with the sample of the −22.5° channel at the same position.
- R3: Q is the sum, over the four sample positions, of the truncated product of the current sample with the sample of the +67.5° channel at the same position.
- R4: A truncated product is the upper byte of the 16-bit signed product, i.e. floor(a·b / 256); for example 1·(−1) gives −1.
- R5: F and Q are held in signed accumulators of ACC_W bits (default 10) that clamp to [−2^(ACC_W−1), 2^(ACC_W−1)−1] instead of wrapping.
- R6: The first bit sent is 1 when Q is negative and 0 otherwise. The second bit is 1 when F is negative and 0 otherwise.
- R7: The third bit is 1 when |F| > |Q| and 0 otherwise, including when the two are equal.
- R8: Samples are captured on the clock edge where ivl_strobe is high. The tribit is ready two edges later. From then on, each edge with bit_tick high registers the next bit on bit_out and raises bit_vld for exactly that one cycle. bit_vld is low in the two cycles after a strobe edge and is never high unless bit_tick was high at the previous edge.
- R9: At most three bits are sent per interval. bit_tick has no effect while no bits are pending, including before the first strobe.
- R10: An interval strobe discards any bits of the previous interval that have not yet been sent. The following ticks send the three bits of the new interval.
- R11: While rst is high and in the cycle after it falls, bit_vld and bit_out are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ivl_strobe | input | 1 | Interval strobe; samples are captured on this edge |
| cur_smp | input | 32 | Four current samples, sample k at bits [8k+7:8k], offset binary complemented |
| qph_smp | input | 32 | Four previous-interval samples after the −22.5° shift |
| qqd_smp | input | 32 | Four previous-interval samples after the +67.5° shift |
| bit_tick | input | 1 | Bit-clock enable; one bit leaves per tick |
| bit_out | output | 1 | Serial tribit output, registered |
| bit_vld | output | 1 | High for one cycle with each bit sent |

## Verification
The hardest conditions to reach from the ports are accumulator clamping and the cases that depend on rounding direction. With full-scale 8-bit samples, the sums never exceed about ±256, so the default width cannot clamp. The bench therefore runs a second instance with an 8-bit accumulator beside the default one. It drives both with full-scale codes chosen so that clamping, wrapping and the unclamped result each give a different tribit. A ±1 sample pair separates floor truncation from truncation toward zero. Interrupted shifts are reached by sending a new strobe after only one tick.

// File: rtl/tribit_pkg.sv
package tribit_pkg;
  typedef struct packed {
    logic neg_q;
    logic neg_f;
    logic f_dom;
  } tribit_t;
endpackage

// File: rtl/cob_conv.sv
module cob_conv #(
  parameter int W = 8
) (
  input  logic [W-1:0]        code,
  output logic signed [W-1:0] val
);
  localparam logic [W-1:0] FLIP = {1'b0, {(W-1){1'b1}}};
  assign val = signed'(code ^ FLIP);
endmodule

// File: rtl/proj_mac.sv
module proj_mac #(
  parameter int W     = 8,
  parameter int N     = 4,
  parameter int ACC_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cap,
  input  logic [N*W-1:0]          a_flat,
  input  logic [N*W-1:0]          b_flat,
  output logic signed [ACC_W-1:0] acc_q
);
  localparam int SUM_W = W + $clog2(N) + 1;
  localparam int PW    = 2 * W;

  logic signed [W-1:0]     a_s [N];
  logic signed [W-1:0]     b_s [N];
  logic signed [PW-1:0]    prod [N];
  logic signed [SUM_W-1:0] sum;
  logic signed [ACC_W-1:0] acc_d;

  for (genvar k = 0; k < N; k++) begin : g_conv
    cob_conv #(.W(W)) ca_i (.code(a_flat[k*W +: W]), .val(a_s[k]));
    cob_conv #(.W(W)) cb_i (.code(b_flat[k*W +: W]), .val(b_s[k]));
    assign prod[k] = PW'(a_s[k]) * PW'(b_s[k]);
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < N; k++)
      sum = sum + signed'({{(SUM_W-W){prod[k][PW-1]}}, prod[k][PW-1:W]});
  end

  if (ACC_W >= SUM_W) begin : g_wide
    assign acc_d = ACC_W'(sum);
  end else begin : g_clamp
    localparam logic signed [SUM_W-1:0] HI = SUM_W'((2 ** (ACC_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] LO = -SUM_W'(2 ** (ACC_W - 1));
    always_comb begin
      if (sum > HI)      acc_d = ACC_W'(HI);
      else if (sum < LO) acc_d = ACC_W'(LO);
      else               acc_d = ACC_W'(sum);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      acc_q <= '0;
    else if (cap) acc_q <= acc_d;
  end
endmodule

// File: rtl/tribit_shifter.sv
module tribit_shifter
  import tribit_pkg::*;
#(
  parameter int ACC_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    abort,
  input  logic                    load,
  input  logic signed [ACC_W-1:0] f_val,
  input  logic signed [ACC_W-1:0] q_val,
  input  logic                    bit_tick,
  output logic                    bit_out,
  output logic                    bit_vld
);
  tribit_t        dec;
  logic [ACC_W:0] f_abs;
  logic [ACC_W:0] q_abs;
  logic [2:0]     shreg;
  logic [1:0]     left;

  always_comb begin
    f_abs = f_val[ACC_W-1] ? (~{f_val[ACC_W-1], f_val} + 1'b1) : {1'b0, f_val};
    q_abs = q_val[ACC_W-1] ? (~{q_val[ACC_W-1], q_val} + 1'b1) : {1'b0, q_val};
    dec.neg_q = q_val[ACC_W-1];
    dec.neg_f = f_val[ACC_W-1];
    dec.f_dom = f_abs > q_abs;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      left    <= '0;
      bit_out <= 1'b0;
      bit_vld <= 1'b0;
    end else begin
      bit_vld <= 1'b0;
      if (abort) begin
        left <= '0;
      end else if (load) begin
        shreg <= dec;
        left  <= 2'd3;
      end else if (bit_tick && left != 2'd0) begin
        bit_out <= shreg[2];
        shreg   <= {shreg[1:0], 1'b0};
        left    <= left - 2'd1;
        bit_vld <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tribit_detector.sv
module tribit_detector #(
  parameter int W     = 8,
  parameter int N     = 4,
  parameter int ACC_W = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ivl_strobe,
  input  logic [N*W-1:0] cur_smp,
  input  logic [N*W-1:0] qph_smp,
  input  logic [N*W-1:0] qqd_smp,
  input  logic           bit_tick,
  output logic           bit_out,
  output logic           bit_vld
);
  logic signed [ACC_W-1:0] f_acc;
  logic signed [ACC_W-1:0] q_acc;
  logic                    proj_vld;

  proj_mac #(.W(W), .N(N), .ACC_W(ACC_W)) f_mac_i (
    .clk(clk), .rst(rst), .cap(ivl_strobe),
    .a_flat(cur_smp), .b_flat(qph_smp), .acc_q(f_acc));

  proj_mac #(.W(W), .N(N), .ACC_W(ACC_W)) q_mac_i (
    .clk(clk), .rst(rst), .cap(ivl_strobe),
    .a_flat(cur_smp), .b_flat(qqd_smp), .acc_q(q_acc));

  always_ff @(posedge clk) begin
    if (rst) proj_vld <= 1'b0;
    else     proj_vld <= ivl_strobe;
  end

  tribit_shifter #(.ACC_W(ACC_W)) shf_i (
    .clk(clk), .rst(rst), .abort(ivl_strobe), .load(proj_vld),
    .f_val(f_acc), .q_val(q_acc), .bit_tick(bit_tick),
    .bit_out(bit_out), .bit_vld(bit_vld));
endmodule

// File: rtl/tribit_det_chk.sv
module tribit_det_chk (
  input logic clk,
  input logic rst,
  input logic ivl_strobe,
  input logic bit_tick,
  input logic bit_vld
);
  logic [2:0] sent;

  always_ff @(posedge clk) begin
    if (rst || ivl_strobe)           sent <= '0;
    else if (bit_vld && sent != 3'd7) sent <= sent + 3'd1;
  end

  AST_BIT_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst) bit_vld |-> $past(bit_tick)); // R8
  AST_STROBE_GAP_A: assert property (@(posedge clk) disable iff (rst) $past(ivl_strobe) |-> !bit_vld); // R10
  AST_STROBE_GAP_B: assert property (@(posedge clk) disable iff (rst) $past(ivl_strobe) |=> !bit_vld); // R8
  AST_MAX_THREE: assert property (@(posedge clk) disable iff (rst) sent <= 3'd3); // R9
  AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> !bit_vld); // R11
endmodule

bind tribit_detector tribit_det_chk chk_i (
  .clk(clk), .rst(rst), .ivl_strobe(ivl_strobe), .bit_tick(bit_tick), .bit_vld(bit_vld));

// File: tb/tribit_detector_tb.sv
module tribit_detector_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        ivl_strobe;
  logic        bit_tick;
  logic [31:0] cur_smp, qph_smp, qqd_smp;
  logic        d_out, d_vld, s_out, s_vld;
  int          n_chk = 0;
  int          n_fail = 0;
  bit [2:0]    exp_d, exp_s;

  always #5 clk = ~clk;

  tribit_detector dut_i (
    .clk(clk), .rst(rst), .ivl_strobe(ivl_strobe), .cur_smp(cur_smp),
    .qph_smp(qph_smp), .qqd_smp(qqd_smp), .bit_tick(bit_tick),
    .bit_out(d_out), .bit_vld(d_vld));

  tribit_detector #(.ACC_W(8)) dut_sat_i (
    .clk(clk), .rst(rst), .ivl_strobe(ivl_strobe), .cur_smp(cur_smp),
    .qph_smp(qph_smp), .qqd_smp(qqd_smp), .bit_tick(bit_tick),
    .bit_out(s_out), .bit_vld(s_vld));

  task automatic check(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  function automatic int trunc_prod(int a, int b);
    int p = a * b;
    return p >>> 8;
  endfunction

  function automatic bit [2:0] model(int c[4], int p[4], int q[4], int aw);
    int f = 0, qs = 0, hi, lo, fa, qa;
    for (int k = 0; k < 4; k++) begin
      f  += trunc_prod(127 - c[k], 127 - p[k]);
      qs += trunc_prod(127 - c[k], 127 - q[k]);
    end
    hi = (1 << (aw - 1)) - 1;
    lo = -(1 << (aw - 1));
    if (f > hi) f = hi;
    if (f < lo) f = lo;
    if (qs > hi) qs = hi;
    if (qs < lo) qs = lo;
    fa = (f < 0) ? -f : f;
    qa = (qs < 0) ? -qs : qs;
    return {qs < 0, f < 0, fa > qa};
  endfunction

  task automatic send(int c[4], int p[4], int q[4]);
    @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      cur_smp[k*8 +: 8] = c[k][7:0];
      qph_smp[k*8 +: 8] = p[k][7:0];
      qqd_smp[k*8 +: 8] = q[k][7:0];
    end
    exp_d = model(c, p, q, 10);
    exp_s = model(c, p, q, 8);
    ivl_strobe = 1'b1;
    @(negedge clk);
    ivl_strobe = 1'b0;
    check("R8 vld low after strobe", int'(d_vld), 0);
    @(negedge clk);
  endtask

  task automatic shift(int first, int count, string req);
    for (int b = first; b < first + count; b++) begin
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
      check({req, " vld"}, int'(d_vld), 1);
      check({req, " bit"}, int'(d_out), int'(exp_d[2-b]));
      check({req, " sat vld"}, int'(s_vld), 1);
      check({req, " sat bit"}, int'(s_out), int'(exp_s[2-b]));
      @(negedge clk);
      check("R8 vld one cycle", int'(d_vld), 0);
    end
  endtask

  task automatic spare_tick();
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    check("R9 no fourth bit", int'(d_vld), 0);
    check("R9 no fourth bit sat", int'(s_vld), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int c[4], p[4], q[4];
    void'($urandom(32'd2024));
    rst = 1'b1; ivl_strobe = 1'b0; bit_tick = 1'b0;
    cur_smp = '0; qph_smp = '0; qqd_smp = '0;
    repeat (3) @(negedge clk);
    check("R11 reset vld", int'(d_vld), 0);
    check("R11 reset out", int'(d_out), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R11 after reset vld", int'(d_vld), 0);
    check("R11 after reset out", int'(d_out), 0);
    spare_tick();
    spare_tick();

    // R6 R7: Q>0, F<0, |F|>|Q| -> 0,1,1
    c = '{27, 27, 27, 27}; p = '{227, 227, 227, 227}; q = '{77, 77, 77, 77};
    send(c, p, q);
    check("R6 model sanity", int'(exp_d), 3);
    shift(0, 3, "R6 R7 sign and magnitude");
    spare_tick();

    // R4: 1 * -1 truncates to -1 per product
    c = '{126, 126, 126, 126}; p = '{128, 128, 128, 128}; q = '{127, 127, 127, 127};
    send(c, p, q);
    shift(0, 3, "R4 floor product");

    // R7: equal magnitudes give third bit 0
    c = '{27, 27, 27, 27}; p = '{27, 27, 27, 27}; q = '{27, 27, 27, 27};
    send(c, p, q);
    shift(0, 3, "R7 tie");

    // R1: full-scale codes
    c = '{0, 0, 0, 0}; p = '{0, 0, 0, 0}; q = '{255, 255, 255, 255};
    send(c, p, q);
    check("R1 model sanity", int'(exp_d), 4);
    shift(0, 3, "R1 code conversion");

    // R5: F=256, Q=252 clamp to equal values in the narrow instance
    c = '{255, 255, 255, 255}; p = '{255, 255, 255, 255}; q = '{254, 254, 254, 254};
    send(c, p, q);
    check("R5 wide expect", int'(exp_d), 1);
    check("R5 clamp expect", int'(exp_s), 0);
    shift(0, 3, "R5 clamp");

    // R10: abort after one bit
    c = '{27, 27, 27, 27}; p = '{227, 227, 227, 227}; q = '{77, 77, 77, 77};
    send(c, p, q);
    shift(0, 1, "R10 first bit");
    c = '{0, 0, 0, 0}; p = '{0, 0, 0, 0}; q = '{255, 255, 255, 255};
    send(c, p, q);
    shift(0, 3, "R10 new interval");
    spare_tick();

    // R2 R3: random intervals
    for (int n = 0; n < 60; n++) begin
      for (int k = 0; k < 4; k++) begin
        c[k] = int'($urandom % 256);
        p[k] = int'($urandom % 256);
        q[k] = int'($urandom % 256);
      end
      send(c, p, q);
      shift(0, 3, "R2 R3 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule